// File: doc/BRIEF.md
# Far-End Alarm Code Validator

This block receives far-end alarm and control code words that an upstream deframer has already pulled out of the line. Each word is a 6-bit code that comes with a one-cycle strobe. The block keeps the ten most recent words in a history window. It confirms a code once that code fills at least eight of the ten slots. It then holds the confirmed code and withdraws it once three or more of the last ten words disagree with it. Because acceptance needs eight agreeing words and withdrawal needs only three disagreeing ones, a code that briefly wins a noisy window is not confirmed. A code that is being lost is dropped quickly.

A confirmed code and its flag are driven straight out. Confirmation and withdrawal each set their own sticky status bit. Each status bit has its own enable bit, and the interrupt line is raised by any status bit whose enable is set. A small read/write register port gives access to these four bits. A read returns the register and clears both status bits at that clock edge. An event that lands in the same cycle as a read is kept.

Top module: `feac_validator`

## Requirements
- R1: After reset, `code_valid_o` and `irq_o` are 0, and the register reads 0x00 (all status and enable bits clear).
- R2: While no code is confirmed, a strobed code that, once taken in, occupies at least 8 of the 10 newest window slots becomes confirmed at that same clock edge. `code_o` shows it and `code_valid_o` is 1.
- R3: A code that occupies only 7 of the 10 newest slots is not confirmed.
- R4: No decision is made until 10 words have been received since reset. Ten identical words confirm at the tenth strobe, not at the ninth.
- R5: A confirmed code is withdrawn, and `code_valid_o` falls, at the strobe after which 3 or more of the 10 newest words differ from it.
- R6: While confirmed, `code_o` does not change, and two differing words in the window do not withdraw it.
- R7: Register bit 0 (accept status) is set when a code is confirmed. Bit 2 (drop status) is set when a code is withdrawn.
- R8: A read (`reg_rd_i` high for one cycle) returns the current register value on `reg_rdata_o` and clears bits 0 and 2 at that edge. Bits 1 and 3 are unaffected by the read.
- R9: Bits 1 (accept enable) and 3 (drop enable) are written from `reg_wdata_i` when `reg_wr_i` is high. Bits 0, 2 and 7..4 cannot be written, and bits 7..4 read as 0.
- R10: `irq_o` equals (bit0 AND bit1) OR (bit2 AND bit3). A status bit whose enable is 0 does not raise it.
- R11: A status event in the same cycle as a read leaves the status bit set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| code_i | input | 6 | Received code word |
| code_stb_i | input | 1 | One-cycle strobe marking a new code word |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status bits) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| code_o | output | 6 | Confirmed code |
| code_valid_o | output | 1 | A code is currently confirmed |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a status event that arrives in the same cycle as a clearing read. The history has to be loaded so that one particular strobe tips the vote. The bench does this after a withdrawal: it feeds a long run of the old code until the window sits at exactly seven matches. It then issues the eighth matching strobe together with the read. The exact eight-of-ten, seven-of-ten and three-mismatch boundaries are reached the same way, by building windows whose oldest slots are known so that each shift removes a chosen word.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned BIT_ACC_ST = 0;
  localparam int unsigned BIT_ACC_EN = 1;
  localparam int unsigned BIT_DRP_ST = 2;
  localparam int unsigned BIT_DRP_EN = 3;

  typedef enum logic {
    VS_SEARCH = 1'b0,
    VS_HOLD   = 1'b1
  } vote_state_e;
endpackage

// File: rtl/feac_history.sv
module feac_history #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned DEPTH  = 10,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] cmp_i,
  output logic [CNT_W-1:0]  match_cnt_o,
  output logic              full_o
);
  logic [CODE_W-1:0] win_q [DEPTH];
  logic [CODE_W-1:0] win_d [DEPTH];
  logic [CNT_W-1:0]  fill_q, fill_d;

  // window shift: slot 0 is newest
  always_comb win_d[0] = shift_i ? code_i : win_q[0];
  for (genvar k = 1; k < DEPTH; k++) begin : g_shift
    always_comb win_d[k] = shift_i ? win_q[k-1] : win_q[k];
  end

  always_comb begin
    fill_d = fill_q;
    if (shift_i && (fill_q < CNT_W'(DEPTH))) fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      for (int k = 0; k < DEPTH; k++) win_q[k] <= '0;
    end else if (shift_i) begin
      fill_q <= fill_d;
      for (int k = 0; k < DEPTH; k++) win_q[k] <= win_d[k];
    end
  end

  // match count over the window as it will be after this shift
  always_comb begin
    match_cnt_o = {{(CNT_W-1){1'b0}}, (code_i == cmp_i)};
    for (int k = 0; k < DEPTH - 1; k++)
      match_cnt_o = match_cnt_o + {{(CNT_W-1){1'b0}}, (win_q[k] == cmp_i)};
  end

  assign full_o = (fill_q >= CNT_W'(DEPTH - 1));

  // R4
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/feac_vote.sv
module feac_vote
  import feac_pkg::*;
#(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned ACCEPT = 8,
  parameter int unsigned DROP   = 3,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CNT_W-1:0]  match_cnt_i,
  input  logic              full_i,
  output logic [CODE_W-1:0] cmp_o,
  output logic [CODE_W-1:0] held_o,
  output logic              valid_o,
  output logic              evt_acc_o,
  output logic              evt_drop_o
);
  vote_state_e       st_q, st_d;
  logic [CODE_W-1:0] held_q, held_d;
  logic [CNT_W-1:0]  miss_cnt;

  assign cmp_o    = (st_q == VS_HOLD) ? held_q : code_i;
  assign miss_cnt = CNT_W'(DEPTH) - match_cnt_i;

  always_comb begin
    st_d       = st_q;
    held_d     = held_q;
    evt_acc_o  = 1'b0;
    evt_drop_o = 1'b0;
    if (stb_i && full_i) begin
      case (st_q)
        VS_SEARCH: if (match_cnt_i >= CNT_W'(ACCEPT)) begin
          st_d      = VS_HOLD;
          held_d    = code_i;
          evt_acc_o = 1'b1;
        end
        VS_HOLD: if (miss_cnt >= CNT_W'(DROP)) begin
          st_d       = VS_SEARCH;
          evt_drop_o = 1'b1;
        end
        default: st_d = VS_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= VS_SEARCH;
      held_q <= '0;
    end else if (stb_i) begin
      st_q   <= st_d;
      held_q <= held_d;
    end
  end

  assign held_o  = held_q;
  assign valid_o = (st_q == VS_HOLD);

  // R2
  acc_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(stb_i));
  // R6
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(valid_o)) |-> $stable(held_q));
  // R5
  drop_only_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop_o |=> !valid_o);
endmodule

// File: rtl/feac_irq_regs.sv
module feac_irq_regs
  import feac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             evt_acc_i,
  input  logic             evt_drop_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  logic acc_st_q, acc_st_d, drp_st_q, drp_st_d;
  logic acc_en_q, drp_en_q;

  always_comb begin
    acc_st_d = (acc_st_q & ~rd_i) | evt_acc_i;
    drp_st_d = (drp_st_q & ~rd_i) | evt_drop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_st_q <= 1'b0;
      drp_st_q <= 1'b0;
    end else begin
      acc_st_q <= acc_st_d;
      drp_st_q <= drp_st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_en_q <= 1'b0;
      drp_en_q <= 1'b0;
    end else if (wr_i) begin
      acc_en_q <= wdata_i[BIT_ACC_EN];
      drp_en_q <= wdata_i[BIT_DRP_EN];
    end
  end

  always_comb begin
    rdata_o             = '0;
    rdata_o[BIT_ACC_ST] = acc_st_q;
    rdata_o[BIT_ACC_EN] = acc_en_q;
    rdata_o[BIT_DRP_ST] = drp_st_q;
    rdata_o[BIT_DRP_EN] = drp_en_q;
  end

  assign irq_o = (acc_st_q & acc_en_q) | (drp_st_q & drp_en_q);

  // R7
  acc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_acc_i |=> acc_st_q);
  // R8
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !evt_acc_i && !evt_drop_i) |=> (!acc_st_q && !drp_st_q));
  // R9
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(acc_en_q) && $stable(drp_en_q)));
endmodule

// File: rtl/feac_validator.sv
module feac_validator #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned ACCEPT = 8,
  parameter int unsigned DROP   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_stb_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [CODE_W-1:0] code_o,
  output logic              code_valid_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CODE_W-1:0] cmp;
  logic [CNT_W-1:0]  match_cnt;
  logic              full, evt_acc, evt_drop;

  feac_history #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_i(code_stb_i), .code_i(code_i),
    .cmp_i(cmp), .match_cnt_o(match_cnt), .full_o(full)
  );

  feac_vote #(.CODE_W(CODE_W), .DEPTH(DEPTH), .ACCEPT(ACCEPT), .DROP(DROP)) u_vote (
    .clk(clk), .rst_n(rst_n), .stb_i(code_stb_i), .code_i(code_i),
    .match_cnt_i(match_cnt), .full_i(full), .cmp_o(cmp), .held_o(code_o),
    .valid_o(code_valid_o), .evt_acc_o(evt_acc), .evt_drop_o(evt_drop)
  );

  feac_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .wdata_i(reg_wdata_i), .evt_acc_i(evt_acc), .evt_drop_i(evt_drop),
    .rdata_o(reg_rdata_o), .irq_o(irq_o)
  );
endmodule

// File: tb/tb_feac_validator.sv
module tb_feac_validator;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] code_i;
  logic       code_stb_i, reg_wr_i, reg_rd_i;
  logic [7:0] reg_wdata_i, reg_rdata_o;
  logic [5:0] code_o;
  logic       code_valid_o, irq_o;
  int         n_chk = 0, n_bad = 0;

  localparam logic [5:0] CA = 6'h15, CB = 6'h2A, CX = 6'h07;

  always #2 clk = ~clk;

  feac_validator dut (
    .clk(clk), .rst_n(rst_n), .code_i(code_i), .code_stb_i(code_stb_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .code_o(code_o), .code_valid_o(code_valid_o),
    .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [5:0] c);
    @(negedge clk); code_i = c; code_stb_i = 1'b1;
    @(negedge clk); code_stb_i = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); reg_rd_i = 1'b1; d = reg_rdata_o;
    @(negedge clk); reg_rd_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_wr_i = 1'b1; reg_wdata_i = d;
    @(negedge clk); reg_wr_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; code_i = '0; code_stb_i = 0; reg_wr_i = 0; reg_rd_i = 0; reg_wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R1 valid", {7'd0, code_valid_o}, 8'd0);
    chk("R1 irq", {7'd0, irq_o}, 8'd0);
    rd(d); chk("R1 reg", d, 8'h00);
  endtask

  task automatic t_fill();
    do_reset();
    for (int i = 0; i < 9; i++) push(CA);
    chk("R4 nine words", {7'd0, code_valid_o}, 8'd0);
    push(CA);
    chk("R4 tenth word", {7'd0, code_valid_o}, 8'd1);
    chk("R4 code", {2'd0, code_o}, {2'd0, CA});
  endtask

  task automatic t_vote();
    logic [7:0] d;
    do_reset();
    wr(8'hFF);
    rd(d); chk("R9 write masks", d, 8'h0A);
    for (int i = 0; i < 3; i++) push(CX);
    for (int i = 0; i < 7; i++) push(CA);
    chk("R3 seven of ten", {7'd0, code_valid_o}, 8'd0);
    chk("R10 no irq", {7'd0, irq_o}, 8'd0);
    push(CA);
    chk("R2 eight of ten", {7'd0, code_valid_o}, 8'd1);
    chk("R2 code", {2'd0, code_o}, {2'd0, CA});
    chk("R10 irq on accept", {7'd0, irq_o}, 8'd1);
    rd(d); chk("R7 accept status", d, 8'h0B);
    rd(d); chk("R8 cleared", d, 8'h0A);
    chk("R8 irq cleared", {7'd0, irq_o}, 8'd0);
    push(CB); push(CB);
    chk("R6 two misses", {7'd0, code_valid_o}, 8'd1);
    chk("R6 code kept", {2'd0, code_o}, {2'd0, CA});
    push(CB);
    chk("R5 three misses", {7'd0, code_valid_o}, 8'd0);
    chk("R10 irq on drop", {7'd0, irq_o}, 8'd1);
    rd(d); chk("R7 drop status", d, 8'h0E);
    // window now A7 B3: seven more A keep it at seven matches
    for (int i = 0; i < 7; i++) push(CA);
    chk("R3 held at seven", {7'd0, code_valid_o}, 8'd0);
    wr(8'h00);
    // eighth match together with a read
    @(negedge clk); code_i = CA; code_stb_i = 1'b1; reg_rd_i = 1'b1; d = reg_rdata_o;
    @(negedge clk); code_stb_i = 1'b0; reg_rd_i = 1'b0;
    chk("R11 read value", d, 8'h00);
    chk("R10 irq masked", {7'd0, irq_o}, 8'd0);
    rd(d); chk("R11 status kept", d, 8'h01);
    chk("R2 reaccept", {7'd0, code_valid_o}, 8'd1);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_vote();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule